// File: doc/BRIEF.md
# Cursor Generator Host Register Port

This block is the host-facing side of a hardware cursor generator. A host reaches it through four word-aligned ports: two that load a shared 16-bit pointer one byte at a time, one that moves 16-bit words into or out of a 512-word cursor pattern memory, and one that moves bytes into or out of a bank of thirteen control registers. Every access to either data port steps the pointer by one, so a run of registers or a whole cursor pattern can be streamed after a single pointer load.

The block turns the register bank into ready-decoded outputs: the cursor and crosshair enables, the combining mode, the output multiplexing ratio, the crosshair thickness, and the 12-bit cursor position and crosshair window values. The pixel pipeline reads the pattern memory through a separate registered port that never conflicts with host traffic. Byte-wide data on the bus is mirrored into both halves of the 16-bit word.

Top module: `cursor_host_port`

## Requirements
- R1: After reset every register, every pattern word and the pointer are zero, so all decoded outputs, `bus_rdata` and `pix_data` read zero.
- R2: `bus_sel` picks the port (0 pointer low byte, 1 pointer high byte, 2 pattern word, 3 register byte). A write on port 0 or 1 loads `bus_wdata[7:0]` into bits 7:0 or 15:8 of the pointer; a read of port 0 or 1 returns that pointer byte in both halves of `bus_rdata` and leaves the pointer unchanged. Read data appears on `bus_rdata` one cycle after the read request and holds until the next read.
- R3: A write on port 3 stores `bus_wdata[7:0]` into the register the pointer selects; a read on port 3 returns that register byte mirrored in both halves of `bus_rdata`.
- R4: Each read or write on port 2 or 3 advances the pointer by one, wrapping from 0xFFFF to 0x0000.
- R5: Register 0 is decoded as: bit 6 cursor enable, bit 5 crosshair enable, bit 4 OR combining when 1 and XOR when 0, bits 3:2 multiplexing ratio code, bits 1:0 crosshair thickness code; bit 7 has no effect.
- R6: Registers 1/2 form the cursor X, 3/4 cursor Y, 5/6 window X, 7/8 window Y, 9/10 window width, 11/12 window height (odd index low byte, even index high byte). Only bits 3:0 of each high byte are kept, giving 12-bit values; its upper bits read back zero.
- R7: A port-3 access at a pointer of 13 or above changes no register and reads zero, but still advances the pointer.
- R8: A port-2 write stores the full 16-bit word at pattern address pointer[8:0] when the pointer is below 512, and a port-2 read returns that word; at a pointer of 512 or above a write changes nothing and a read returns zero.
- R9: `pix_data` shows the pattern word at `pix_addr` one clock after `pix_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 2 | Port select (word offset bits 3:2) |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read |
| cursor_on | output | 1 | Cursor enable |
| xhair_on | output | 1 | Crosshair enable |
| or_combine | output | 1 | 1 OR-combines cursor and crosshair, 0 XOR-combines |
| mux_mode | output | 2 | Output multiplexing ratio code |
| xhair_thick | output | 2 | Crosshair thickness code |
| cursor_x | output | 12 | Cursor X position |
| cursor_y | output | 12 | Cursor Y position |
| win_x | output | 12 | Crosshair window X |
| win_y | output | 12 | Crosshair window Y |
| win_w | output | 12 | Crosshair window width |
| win_h | output | 12 | Crosshair window height |
| pix_addr | input | 9 | Pixel-side pattern address |
| pix_data | output | 16 | Pixel-side pattern word |

## Verification
On every cycle the assertions check the pointer stepping on data-port accesses and staying put otherwise, the mirrored form of register reads, that register writes past the bank leave every decoded output unchanged, and that pattern reads past the memory return zero. What value lands in which register, the command bit decode, the 4-bit trimming of high bytes, the wrap of the pointer and the pixel-port latency can only be shown by the bench scenarios, which compare every read and output against a model of the bank and memory under a seeded random mix of pointer loads, register and pattern accesses.

// File: rtl/cursor_host_port.sv
module cursor_host_port #(
  parameter int PTR_W  = 16,
  parameter int MAP_AW = 9,
  parameter int MAP_W  = 16,
  parameter int NREG   = 13,
  parameter int POS_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [MAP_W-1:0]  bus_wdata,
  output logic [MAP_W-1:0]  bus_rdata,
  output logic              cursor_on,
  output logic              xhair_on,
  output logic              or_combine,
  output logic [1:0]        mux_mode,
  output logic [1:0]        xhair_thick,
  output logic [POS_W-1:0]  cursor_x,
  output logic [POS_W-1:0]  cursor_y,
  output logic [POS_W-1:0]  win_x,
  output logic [POS_W-1:0]  win_y,
  output logic [POS_W-1:0]  win_w,
  output logic [POS_W-1:0]  win_h,
  input  logic [MAP_AW-1:0] pix_addr,
  output logic [MAP_W-1:0]  pix_data
);
  localparam int MAP_DEPTH = 1 << MAP_AW;
  localparam int RIDX_W    = $clog2(NREG);
  localparam int HI_W      = POS_W - 8;
  localparam logic [7:0] HI_MASK = 8'((1 << HI_W) - 1);

  logic [PTR_W-1:0]  ptr;
  logic [7:0]        regs [NREG];
  logic [MAP_W-1:0]  map  [MAP_DEPTH];

  wire data_acc = (bus_wr | bus_rd) & bus_sel[1];
  wire reg_hit  = ptr < PTR_W'(NREG);
  wire map_hit  = ptr < PTR_W'(MAP_DEPTH);
  wire is_hi    = ~ptr[0] & (ptr != '0);
  wire [RIDX_W-1:0] ridx = ptr[RIDX_W-1:0];
  wire [7:0] wbyte = bus_wdata[7:0] & (is_hi ? HI_MASK : 8'hFF);
  wire [7:0] rbyte = reg_hit ? regs[ridx] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr <= '0;
    else if (bus_wr && bus_sel == 2'd0)
      ptr[7:0] <= bus_wdata[7:0];
    else if (bus_wr && bus_sel == 2'd1)
      ptr[PTR_W-1:8] <= bus_wdata[PTR_W-9:0];
    else if (data_acc)
      ptr <= ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (bus_wr && bus_sel == 2'd3 && reg_hit) begin
      regs[ridx] <= wbyte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MAP_DEPTH; i++) map[i] <= '0;
      pix_data <= '0;
    end else begin
      if (bus_wr && bus_sel == 2'd2 && map_hit)
        map[ptr[MAP_AW-1:0]] <= bus_wdata;
      pix_data <= map[pix_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_sel)
        2'd0:    bus_rdata <= {ptr[7:0], ptr[7:0]};
        2'd1:    bus_rdata <= {ptr[15:8], ptr[15:8]};
        2'd2:    bus_rdata <= map_hit ? map[ptr[MAP_AW-1:0]] : '0;
        default: bus_rdata <= {rbyte, rbyte};
      endcase
    end
  end

  assign cursor_on   = regs[0][6];
  assign xhair_on    = regs[0][5];
  assign or_combine  = regs[0][4];
  assign mux_mode    = regs[0][3:2];
  assign xhair_thick = regs[0][1:0];
  assign cursor_x    = {regs[2][HI_W-1:0],  regs[1]};
  assign cursor_y    = {regs[4][HI_W-1:0],  regs[3]};
  assign win_x       = {regs[6][HI_W-1:0],  regs[5]};
  assign win_y       = {regs[8][HI_W-1:0],  regs[7]};
  assign win_w       = {regs[10][HI_W-1:0], regs[9]};
  assign win_h       = {regs[12][HI_W-1:0], regs[11]};
endmodule

// File: rtl/cursor_host_port_chk.sv
module cursor_host_port_chk #(
  parameter int PTR_W  = 16,
  parameter int MAP_AW = 9,
  parameter int NREG   = 13,
  parameter int CTL_W  = 79
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       bus_sel,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [15:0]      bus_rdata,
  input logic [PTR_W-1:0] ptr,
  input logic [CTL_W-1:0] ctl
);
  localparam int MAP_DEPTH = 1 << MAP_AW;

  a_r4_data_access_steps: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && bus_sel[1]) |=> ptr == PTR_W'($past(ptr) + 1'b1));

  a_r2_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_wr && !bus_sel[1]) && !((bus_wr || bus_rd) && bus_sel[1])) |=> $stable(ptr));

  a_r3_reg_read_mirrored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_sel == 2'd3) |=> bus_rdata[15:8] == bus_rdata[7:0]);

  a_r7_high_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 2'd3 && ptr >= PTR_W'(NREG)) |=> $stable(ctl));

  a_r8_map_beyond_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_sel == 2'd2 && ptr >= PTR_W'(MAP_DEPTH)) |=> bus_rdata == '0);
endmodule

bind cursor_host_port cursor_host_port_chk #(
  .PTR_W(PTR_W), .MAP_AW(MAP_AW), .NREG(NREG), .CTL_W(7 + 6 * POS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .ptr(ptr),
  .ctl({cursor_on, xhair_on, or_combine, mux_mode, xhair_thick,
        cursor_x, cursor_y, win_x, win_y, win_w, win_h})
);

// File: tb/cursor_host_port_tb.sv
module cursor_host_port_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  bus_sel = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        cursor_on, xhair_on, or_combine;
  logic [1:0]  mux_mode, xhair_thick;
  logic [11:0] cursor_x, cursor_y, win_x, win_y, win_w, win_h;
  logic [8:0]  pix_addr = 0;
  logic [15:0] pix_data;

  int tests = 0, fails = 0;
  logic [15:0] m_ptr;
  logic [7:0]  m_reg [13];
  logic [15:0] m_map [512];

  always #5 clk = ~clk;

  cursor_host_port u_dut (.*);

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int idx, logic [7:0] v);
    return (idx != 0 && idx % 2 == 0) ? (v & 8'h0F) : v;
  endfunction

  function automatic logic [11:0] exp_pos(int lo);
    return {m_reg[lo + 1][3:0], m_reg[lo]};
  endfunction

  task automatic bus_write(logic [1:0] s, logic [15:0] d);
    @(negedge clk);
    bus_sel = s; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
    case (s)
      2'd0: m_ptr[7:0] = d[7:0];
      2'd1: m_ptr[15:8] = d[7:0];
      2'd2: begin if (m_ptr < 512) m_map[m_ptr[8:0]] = d; m_ptr++; end
      default: begin if (m_ptr < 13) m_reg[m_ptr] = exp_byte(int'(m_ptr), d[7:0]); m_ptr++; end
    endcase
  endtask

  task automatic bus_read(logic [1:0] s, output logic [15:0] d);
    @(negedge clk);
    bus_sel = s; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
    if (s[1]) m_ptr++;
  endtask

  task automatic set_ptr(logic [15:0] p);
    bus_write(2'd0, {p[7:0], p[7:0]});
    bus_write(2'd1, {p[15:8], p[15:8]});
  endtask

  function automatic logic [15:0] exp_read(logic [1:0] s, logic [15:0] p);
    logic [7:0] b;
    case (s)
      2'd0: return {p[7:0], p[7:0]};
      2'd1: return {p[15:8], p[15:8]};
      2'd2: return (p < 512) ? m_map[p[8:0]] : 16'h0;
      default: begin b = (p < 13) ? m_reg[p] : 8'h00; return {b, b}; end
    endcase
  endfunction

  task automatic check_outputs(string tag);
    check({tag, " R5 cmd"}, {cursor_on, xhair_on, or_combine, mux_mode, xhair_thick},
          {m_reg[0][6], m_reg[0][5], m_reg[0][4], m_reg[0][3:2], m_reg[0][1:0]});
    check({tag, " R6 cursor_x"}, cursor_x, exp_pos(1));
    check({tag, " R6 cursor_y"}, cursor_y, exp_pos(3));
    check({tag, " R6 win_x"}, win_x, exp_pos(5));
    check({tag, " R6 win_y"}, win_y, exp_pos(7));
    check({tag, " R6 win_w"}, win_w, exp_pos(9));
    check({tag, " R6 win_h"}, win_h, exp_pos(11));
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] d, p;
    void'($urandom(32'h1234));
    m_ptr = 0;
    for (int i = 0; i < 13; i++) m_reg[i] = 0;
    for (int i = 0; i < 512; i++) m_map[i] = 0;
    pix_addr = 9'd5;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 rdata", bus_rdata, 16'h0);
    check("R1 pix_data", pix_data, 16'h0);
    check_outputs("R1");

    // R2 pointer load and readback
    set_ptr(16'hA53C);
    bus_read(2'd0, d); check("R2 ptr low", d, 16'h3C3C);
    bus_read(2'd1, d); check("R2 ptr high", d, 16'hA5A5);

    // R5 command decode
    set_ptr(16'h0000);
    bus_write(2'd3, 16'h5E5E);
    check("R5 cmd 5E", {cursor_on, xhair_on, or_combine, mux_mode, xhair_thick}, {1'b1,1'b0,1'b1,2'b11,2'b10});
    set_ptr(16'h0000);
    bus_write(2'd3, 16'hA1A1);
    check("R5 cmd A1", {cursor_on, xhair_on, or_combine, mux_mode, xhair_thick}, {1'b0,1'b1,1'b0,2'b00,2'b01});

    // R4 R6 streamed position writes
    set_ptr(16'h0001);
    bus_write(2'd3, 16'h3434); bus_write(2'd3, 16'hF5F5);
    bus_write(2'd3, 16'h7878); bus_write(2'd3, 16'hAAAA);
    check("R6 cursor_x", cursor_x, 12'h534);
    check("R6 cursor_y", cursor_y, 12'hA78);
    bus_read(2'd0, d); check("R4 ptr after 4 writes", d, 16'h0505);
    set_ptr(16'h0002);
    bus_read(2'd3, d); check("R3 R6 high byte readback", d, 16'h0505);
    bus_read(2'd3, d); check("R3 low byte readback", d, 16'h7878);

    // R7 beyond the bank
    set_ptr(16'h000D);
    bus_write(2'd3, 16'hABAB);
    check_outputs("R7 after write");
    bus_read(2'd0, d); check("R7 ptr still steps", d, 16'h0E0E);
    set_ptr(16'h000D);
    bus_read(2'd3, d); check("R7 read zero", d, 16'h0000);

    // R8 pattern memory
    set_ptr(16'h01FF);
    bus_write(2'd2, 16'hBEEF);
    bus_write(2'd2, 16'h1357);
    set_ptr(16'h01FF);
    bus_read(2'd2, d); check("R8 last word", d, 16'hBEEF);
    bus_read(2'd2, d); check("R8 beyond read zero", d, 16'h0000);
    set_ptr(16'h0000);
    bus_read(2'd2, d); check("R8 word 0 untouched", d, 16'h0000);

    // R4 wrap
    set_ptr(16'hFFFF);
    bus_read(2'd2, d);
    bus_read(2'd0, d); check("R4 wrap low", d, 16'h0000);
    bus_read(2'd1, d); check("R4 wrap high", d, 16'h0000);

    // R9 pixel port
    @(negedge clk); pix_addr = 9'h1FF;
    @(negedge clk); check("R9 pix 1FF", pix_data, 16'hBEEF);
    pix_addr = 9'h000;
    @(negedge clk); check("R9 pix 000", pix_data, 16'h0000);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      case (op)
        0: begin
          p = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'($urandom_range(0, 15));
          if ($urandom_range(0, 1) == 1) p = 16'($urandom_range(500, 520));
          set_ptr(p);
        end
        1, 2, 3: bus_write(2'd3, 16'($urandom));
        4, 5: bus_write(2'd2, 16'($urandom));
        6, 7: begin
          p = m_ptr;
          bus_read(2'd3, d); check("R3 random reg read", d, exp_read(2'd3, p));
        end
        8: begin
          p = m_ptr;
          bus_read(2'd2, d); check("R8 random map read", d, exp_read(2'd2, p));
        end
        default: begin
          p = m_ptr;
          bus_read(2'd0, d); check("R2 random ptr read", d, exp_read(2'd0, p));
        end
      endcase
    end
    check_outputs("R6 random end");
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); pix_addr = 9'($urandom_range(500, 511));
      @(negedge clk); check("R9 random pix", pix_data, m_map[pix_addr]);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule